// File: doc/BRIEF.md
# Programmable SPI Bus Master

This block is an SPI master that a processor controls through a small register file. The register file sits on a simple synchronous read/write bus. Software loads a clock divider and a command word. The command word picks the frame length, the clock polarity and phase, the bit order, the slave-select line and whether that select stays low between frames. Software then sets the enable and master bits in the control register. Each write to the data register, made while the transmit buffer is empty, queues one word. The master shifts that word out on MOSI and samples MISO at the same time.

In full-duplex operation the received word lands in the data register and sets a receive-full flag. The flag clears when the data register is read. A frame that completes while that flag is still set raises an overrun flag and drops its word. In transmit-only operation nothing is captured. An interrupt output combines the receive-full and transmit-empty flags, each gated by its own enable bit.

Top module: `spiRegMaster`

## Requirements
- R1: After reset the status register reads 0x20 (transmit-empty set; receive-full, busy and overrun clear), both selects are high, SCK is low and the interrupt is low.
- R2: While a frame runs, every SCK transition is (divider+1) × 2^base clock cycles after the previous one. The divider is register 0x0C bits 7:0 and base is command bits 3:2. SCK rests at the CPOL level (command bit 1) when idle.
- R3: Command bits 11:8 set the frame length. Codes 0x7 to 0xF give code+1 bits, 0x0 gives 20, 0x1 gives 24, 0x2 gives 32, and 0x3 to 0x6 give 8.
- R4: Command bit 12 clear sends and receives the most significant bit first; set, the least significant bit first.
- R5: With CPHA (command bit 0) clear, data is sampled on the first, leading, SCK edge of each bit and changed on the trailing edge. With CPHA set, it is changed on the leading edge and sampled on the trailing edge.
- R6: A write to the data register (0x08) is taken only while transmit-empty (status bit 5) is set. A write made while a word is pending leaves that word unchanged. A pending word starts a frame only while enable (control bit 6) and master (control bit 3) are both set.
- R7: In full-duplex operation a completed frame puts the received word in the data register and sets receive-full (status bit 7). A read of the data register clears receive-full.
- R8: A frame that completes while receive-full is set sets overrun (status bit 0) and leaves the data register unchanged. Any write to the status register (0x04) clears overrun.
- R9: With transmit-only (control bit 1) set, frames still drive MOSI but never set receive-full or overrun.
- R10: Command bits 5:4 pick the select line: 0 drives ssN[0], 1 drives ssN[1], and 2 or 3 drive neither. The chosen line is low while enable and master are set and either a frame is running or keep (command bit 7) is set. Clearing enable releases it.
- R11: irq equals (receive-full AND control bit 7) OR (transmit-empty AND control bit 5).
- R12: Status bit 1 is set from the cycle after a frame starts until its last SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address of the register |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe (a data-register read clears receive-full) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 2 | Active-low slave selects |
| irq | output | 1 | Interrupt request |

## Verification
Register writes take effect at the clock edge that captures them. The control-derived outputs (irq, ssN) are combinational and are checked in the low half of the next cycle. A data write is taken at its edge, and the frame loads one edge later. After that, SCK moves every (divider+1)·2^base cycles. Status and the received word update at the edge of the final SCK transition. The bench does not count cycles for each setting. It polls the status register through the bus and samples in mid-cycle, so every flag check falls after the update edge. It measures SCK spacing as the time between transitions seen inside a frame. A bench slave changes MISO and captures MOSI only on the SCK edges that R5 assigns to it. Bit-order and phase errors therefore show up as wrong words.

// File: rtl/spiMstPkg.sv
package spiMstPkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_DATA = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_DIV  = 5'h0C;
  localparam logic [ADDR_W-1:0] ADR_CMD  = 5'h10;

  // strobes from the sequencer to the shifter
  typedef struct packed {
    logic load;    // move pending word into shifter
    logic launch;  // present next bit on MOSI
    logic sample;  // capture MISO
    logic finish;  // last SCK edge of the frame
  } spiStrobeT;
endpackage

// File: rtl/spiMstCtrl.sv
module spiMstCtrl
  import spiMstPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              txFull,
  output spiStrobeT         st,
  output logic              busy,
  output logic              sck,
  output logic [1:0]        ssN,
  output logic              rxIe,
  output logic              txIe,
  output logic              txOnly,
  output logic              lsbFirst,
  output logic [$clog2(DATA_W+1)-1:0] lenBits,
  output logic [7:0]        ctrlByte,
  output logic [DIV_W-1:0]  divVal,
  output logic [15:0]       cmdVal
);
  localparam int LEN_W  = $clog2(DATA_W+1);
  localparam int EDGE_W = LEN_W + 1;
  localparam int HALF_W = DIV_W + 4;

  logic              enQ, masterQ, rxIeQ, txIeQ, txOnlyQ;
  logic [DIV_W-1:0]  divQ;
  logic [15:0]       cmdQ;
  logic              busyQ, sckQ;
  logic [HALF_W-1:0] cnt, halfPer;
  logic [EDGE_W-1:0] edgeIdx;
  logic [LEN_W-1:0]  lenRaw;
  logic              cpol, cpha, startOk, edgeNow, evenEdge, lastEdge, selActive;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ <= 1'b0; masterQ <= 1'b0; rxIeQ <= 1'b0; txIeQ <= 1'b0; txOnlyQ <= 1'b0;
      divQ <= '0; cmdQ <= '0;
    end else if (busWe) begin
      if (busAddr == ADR_CTRL) begin
        rxIeQ   <= busWdata[7];
        enQ     <= busWdata[6];
        txIeQ   <= busWdata[5];
        masterQ <= busWdata[3];
        txOnlyQ <= busWdata[1];
      end
      if (busAddr == ADR_DIV) divQ <= busWdata[DIV_W-1:0];
      if (busAddr == ADR_CMD) cmdQ <= busWdata[15:0];
    end
  end

  assign cpol     = cmdQ[1];
  assign cpha     = cmdQ[0];
  assign lsbFirst = cmdQ[12];
  assign halfPer  = (HALF_W'(divQ) + HALF_W'(1)) << cmdQ[3:2];

  always_comb begin
    case (cmdQ[11:8])
      4'h0:                   lenRaw = LEN_W'(20);
      4'h1:                   lenRaw = LEN_W'(24);
      4'h2:                   lenRaw = LEN_W'(32);
      4'h3, 4'h4, 4'h5, 4'h6: lenRaw = LEN_W'(8);
      default:                lenRaw = LEN_W'(cmdQ[11:8]) + LEN_W'(1);
    endcase
    lenBits = (lenRaw > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : lenRaw;
  end

  assign startOk  = !busyQ && txFull && enQ && masterQ;
  assign edgeNow  = busyQ && (cnt == '0);
  assign evenEdge = !edgeIdx[0];
  assign lastEdge = (edgeIdx == ({1'b0, lenBits, 1'b0} - EDGE_W'(1))) ;

  always_comb begin
    st.load   = startOk;
    st.launch = (startOk && !cpha) ||
                (edgeNow && (cpha ? evenEdge : (!evenEdge && !lastEdge)));
    st.sample = edgeNow && (cpha ? !evenEdge : evenEdge);
    st.finish = edgeNow && lastEdge;
  end

  // frame sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0; sckQ <= 1'b0; cnt <= '0; edgeIdx <= '0;
    end else if (startOk) begin
      busyQ   <= 1'b1;
      sckQ    <= cpol;
      cnt     <= halfPer - HALF_W'(1);
      edgeIdx <= '0;
    end else if (edgeNow) begin
      sckQ    <= ~sckQ;
      edgeIdx <= edgeIdx + EDGE_W'(1);
      cnt     <= halfPer - HALF_W'(1);
      if (lastEdge) busyQ <= 1'b0;
    end else if (busyQ) begin
      cnt <= cnt - HALF_W'(1);
    end else begin
      sckQ <= cpol;
    end
  end

  assign selActive = enQ && masterQ && (busyQ || cmdQ[7]);
  assign ssN[0]    = !(selActive && cmdQ[5:4] == 2'd0);
  assign ssN[1]    = !(selActive && cmdQ[5:4] == 2'd1);

  assign busy     = busyQ;
  assign sck      = sckQ;
  assign rxIe     = rxIeQ;
  assign txIe     = txIeQ;
  assign txOnly   = txOnlyQ;
  assign ctrlByte = {rxIeQ, enQ, txIeQ, 1'b0, masterQ, 1'b0, txOnlyQ, 1'b0};
  assign divVal   = divQ;
  assign cmdVal   = cmdQ;

  // R10
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN) ssN != 2'b00);
  // R10
  sel_release_chk: assert property (@(posedge clk) disable iff (!rstN) !enQ |-> ssN == 2'b11);
  // R2
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && cnt != '0 |=> $stable(sckQ));
  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN) st.load |=> busyQ);
endmodule

// File: rtl/spiMstData.sv
module spiMstData
  import spiMstPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobeT         st,
  input  logic              lsbFirst,
  input  logic              txOnly,
  input  logic [$clog2(DATA_W+1)-1:0] lenBits,
  input  logic              miso,
  input  logic              dataWr,
  input  logic              dataRd,
  input  logic              statWr,
  input  logic [DATA_W-1:0] wdata,
  output logic              mosi,
  output logic              txFull,
  output logic              rxFull,
  output logic              ovr,
  output logic [DATA_W-1:0] rxData
);
  localparam int LEN_W = $clog2(DATA_W+1);

  function automatic logic [DATA_W-1:0] bitRev(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic [DATA_W-1:0] txBuf, shReg, rxSh, loadVal, rxNext, rxWord, lenMask;
  logic [LEN_W-1:0]  padBits;
  logic              mosiQ, txFullQ, rxFullQ, ovrQ;
  logic [DATA_W-1:0] rxDataQ;

  assign padBits = LEN_W'(DATA_W) - lenBits;
  assign loadVal = lsbFirst ? bitRev(txBuf) : (txBuf << padBits);
  assign rxNext  = st.sample ? {rxSh[DATA_W-2:0], miso} : rxSh;
  assign lenMask = {DATA_W{1'b1}} >> padBits;
  assign rxWord  = lsbFirst ? (bitRev(rxNext) >> padBits) : (rxNext & lenMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBuf <= '0; txFullQ <= 1'b0; shReg <= '0; mosiQ <= 1'b0; rxSh <= '0;
      rxDataQ <= '0; rxFullQ <= 1'b0; ovrQ <= 1'b0;
    end else begin
      if (st.load) txFullQ <= 1'b0;
      else if (dataWr && !txFullQ) begin
        txBuf   <= wdata;
        txFullQ <= 1'b1;
      end

      if (st.load) begin
        if (st.launch) begin
          mosiQ <= loadVal[DATA_W-1];
          shReg <= loadVal << 1;
        end else begin
          shReg <= loadVal;
        end
      end else if (st.launch) begin
        mosiQ <= shReg[DATA_W-1];
        shReg <= shReg << 1;
      end

      if (st.sample) rxSh <= rxNext;

      if (statWr) ovrQ <= 1'b0;
      if (st.finish && !txOnly) begin
        if (rxFullQ && !dataRd) ovrQ <= 1'b1;
        else begin
          rxDataQ <= rxWord;
          rxFullQ <= 1'b1;
        end
      end else if (dataRd) begin
        rxFullQ <= 1'b0;
      end
    end
  end

  assign mosi   = mosiQ;
  assign txFull = txFullQ;
  assign rxFull = rxFullQ;
  assign ovr    = ovrQ;
  assign rxData = rxDataQ;

  // R9
  txonly_norx_chk: assert property (@(posedge clk) disable iff (!rstN)
    txOnly && !rxFullQ |=> !rxFullQ);
  // R8
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.finish && !txOnly && rxFullQ && !dataRd |=> $stable(rxDataQ) && ovrQ);
  // R6
  full_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataWr && txFullQ |=> $stable(txBuf));
  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataRd && !st.finish |=> !rxFullQ);
endmodule

// File: rtl/spiRegMaster.sv
module spiRegMaster
  import spiMstPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [1:0]        ssN,
  output logic              irq
);
  localparam int LEN_W = $clog2(DATA_W+1);

  spiStrobeT         st;
  logic              busy, txFull, rxFull, ovr, rxIe, txIe, txOnly, lsbFirst;
  logic [LEN_W-1:0]  lenBits;
  logic [7:0]        ctrlByte;
  logic [DIV_W-1:0]  divVal;
  logic [15:0]       cmdVal;
  logic [DATA_W-1:0] rxData;
  logic              dataWr, dataRd, statWr;

  assign dataWr = busWe && busAddr == ADR_DATA;
  assign dataRd = busRe && busAddr == ADR_DATA;
  assign statWr = busWe && busAddr == ADR_STAT;

  spiMstCtrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .txFull(txFull), .st(st), .busy(busy), .sck(sck), .ssN(ssN),
    .rxIe(rxIe), .txIe(txIe), .txOnly(txOnly), .lsbFirst(lsbFirst), .lenBits(lenBits),
    .ctrlByte(ctrlByte), .divVal(divVal), .cmdVal(cmdVal));

  spiMstData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .st(st), .lsbFirst(lsbFirst), .txOnly(txOnly),
    .lenBits(lenBits), .miso(miso), .dataWr(dataWr), .dataRd(dataRd), .statWr(statWr),
    .wdata(busWdata), .mosi(mosi), .txFull(txFull), .rxFull(rxFull), .ovr(ovr),
    .rxData(rxData));

  always_comb begin
    case (busAddr)
      ADR_CTRL: busRdata = DATA_W'(ctrlByte);
      ADR_STAT: busRdata = DATA_W'({rxFull, 1'b0, !txFull, 3'b000, busy, ovr});
      ADR_DATA: busRdata = rxData;
      ADR_DIV:  busRdata = DATA_W'(divVal);
      ADR_CMD:  busRdata = DATA_W'(cmdVal);
      default:  busRdata = '0;
    endcase
  end

  assign irq = (rxFull && rxIe) || (!txFull && txIe);
endmodule

// File: tb/spiRegMaster_test.sv
`timescale 1ns/1ps
module spiRegMaster_test;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_DATA = 5'h08,
                         A_DIV = 5'h0C, A_CMD = 5'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sck, mosi, irq;
  logic        miso = 1'b0;
  logic [1:0]  ssN;
  logic        ssAll;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spiRegMaster uut (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busRe(busRe), .busWdata(busWdata), .busRdata(busRdata), .sck(sck), .mosi(mosi),
    .miso(miso), .ssN(ssN), .irq(irq));

  assign ssAll = &ssN;

  // bench slave
  int bLen = 8;
  bit bLsb = 0, bCpol = 0, bCpha = 0;
  logic [31:0] slvWord = '0, capWord = '0;
  int slvIdx = 0, capIdx = 0;
  time lastT = 0, gap = 0;
  int rise0 = 0, rise1 = 0, anyFall = 0;

  function automatic int pos(int k);
    return bLsb ? k : bLen - 1 - k;
  endfunction

  task automatic prepSlave(input logic [31:0] w);
    slvWord = w; capWord = '0; capIdx = 0; slvIdx = 0;
    if (!bCpha) begin miso = slvWord[pos(0)]; slvIdx = 1; end
  endtask

  always @(negedge ssAll) begin
    anyFall++;
    capWord = '0; capIdx = 0; slvIdx = 0;
    if (!bCpha) begin miso = slvWord[pos(0)]; slvIdx = 1; end
  end

  always @(posedge ssN[0]) rise0++;
  always @(posedge ssN[1]) rise1++;

  always @(sck) begin
    if (rstN && !ssAll) begin
      gap = $time - lastT; lastT = $time;
      if ((sck != bCpol) ^ bCpha) begin
        if (capIdx < bLen) begin capWord[pos(capIdx)] = mosi; capIdx++; end
      end else begin
        if (slvIdx < bLen) begin miso = slvWord[pos(slvIdx)]; slvIdx++; end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRe = 1'b1; #1 d = busRdata;
    @(negedge clk); busRe = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(A_STAT, v);
      if (!v[1] && v[5]) break;
    end
  endtask

  task automatic waitTxEmpty();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(A_STAT, v);
      if (v[5]) break;
    end
  endtask

  task automatic setCmd(input int len, input bit lsb, input bit keep, input int sel,
                        input int base, input bit cpol, input bit cpha);
    logic [31:0] c;
    c = ((len - 1) << 8) | (32'(lsb) << 12) | (32'(keep) << 7) | (sel << 4) |
        (base << 2) | (32'(cpol) << 1) | 32'(cpha);
    bLen = len; bLsb = lsb; bCpol = cpol; bCpha = cpha;
    wr(A_CMD, c);
  endtask

  task automatic frame(input logic [31:0] tx, input logic [31:0] slv);
    prepSlave(slv);
    wr(A_DATA, tx);
    waitIdle();
  endtask

  task automatic tReset();
    logic [31:0] v;
    rd(A_STAT, v);
    chk("R1 status after reset", v, 32'h20);
    chk("R1 selects after reset", 32'(ssN), 32'h3);
    chk("R1 sck after reset", 32'(sck), 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);
  endtask

  task automatic tMode0Msb8();
    logic [31:0] v;
    wr(A_DIV, 0);
    setCmd(8, 0, 0, 0, 0, 0, 0);
    wr(A_CTRL, 32'h48);
    frame(32'hA5, 32'h3C);
    chk("R5 R3 mode0 MOSI word", capWord, 32'hA5);
    rd(A_STAT, v);
    chk("R7 receive-full after frame", v, 32'hA0);
    rd(A_DATA, v);
    chk("R7 received word", v, 32'h3C);
    rd(A_STAT, v);
    chk("R7 read clears receive-full", v, 32'h20);
  endtask

  task automatic tLsb16Mode3();
    logic [31:0] v;
    setCmd(16, 1, 0, 0, 0, 1, 1);
    frame(32'h1234, 32'hBEEF);
    chk("R4 lsb-first 16-bit MOSI", capWord, 32'h1234);
    rd(A_DATA, v);
    chk("R4 lsb-first 16-bit MISO", v, 32'hBEEF);
    chk("R2 sck idles at cpol=1", 32'(sck), 32'h1);
  endtask

  task automatic tRate();
    logic [31:0] v;
    wr(A_DIV, 2);
    setCmd(8, 0, 0, 0, 1, 0, 1);
    frame(32'h96, 32'h69);
    chk("R2 half period div2 base1", 32'(gap), 32'd120);
    chk("R5 cpha1 MOSI word", capWord, 32'h96);
    rd(A_DATA, v);
    chk("R5 cpha1 MISO word", v, 32'h69);
    chk("R2 sck idles at cpol=0", 32'(sck), 32'h0);
    wr(A_DIV, 4);
    setCmd(8, 0, 0, 0, 0, 0, 0);
    frame(32'h0F, 32'hF0);
    chk("R2 half period div4 base0", 32'(gap), 32'd100);
    rd(A_DATA, v);
  endtask

  task automatic tOverrun();
    logic [31:0] v;
    wr(A_DIV, 0);
    setCmd(8, 0, 0, 0, 0, 0, 0);
    frame(32'h01, 32'h5A);
    frame(32'h02, 32'hC3);
    rd(A_STAT, v);
    chk("R8 overrun set", v, 32'hA1);
    rd(A_DATA, v);
    chk("R8 data kept from first frame", v, 32'h5A);
    wr(A_STAT, 0);
    rd(A_STAT, v);
    chk("R8 status write clears overrun", v, 32'h20);
  endtask

  task automatic tTxOnly();
    logic [31:0] v;
    wr(A_CTRL, 32'h4A);
    frame(32'h77, 32'hFF);
    frame(32'h3E, 32'hFF);
    chk("R9 transmit-only still drives MOSI", capWord, 32'h3E);
    rd(A_STAT, v);
    chk("R9 no receive-full or overrun", v, 32'h20);
    wr(A_CTRL, 32'h48);
  endtask

  task automatic tIgnoredWrite();
    logic [31:0] v;
    wr(A_CTRL, 32'h08);
    prepSlave(32'h00);
    wr(A_DATA, 32'h11);
    rd(A_STAT, v);
    chk("R6 pending word, no frame while disabled", v, 32'h00);
    wr(A_DATA, 32'h22);
    wr(A_CTRL, 32'h48);
    waitIdle();
    chk("R6 second write ignored", capWord, 32'h11);
    rd(A_DATA, v);
  endtask

  task automatic tBusy();
    logic [31:0] v;
    wr(A_DIV, 20);
    prepSlave(32'h00);
    wr(A_DATA, 32'h55);
    rd(A_STAT, v);
    chk("R12 busy during frame", 32'(v[1]), 32'h1);
    waitIdle();
    rd(A_STAT, v);
    chk("R12 busy clear after frame", 32'(v[1]), 32'h0);
    rd(A_DATA, v);
    wr(A_DIV, 0);
  endtask

  task automatic tSelect();
    wr(A_CTRL, 32'h0A);
    setCmd(8, 0, 1, 1, 0, 0, 0);
    wr(A_CTRL, 32'h4A);
    chk("R10 keep asserts ssN[1] while idle", 32'(ssN), 32'h1);
    rise0 = 0; rise1 = 0;
    prepSlave(0); wr(A_DATA, 32'hAA); waitTxEmpty(); wr(A_DATA, 32'h55); waitIdle();
    chk("R10 keep holds select between frames", 32'(rise1), 32'd0);
    chk("R10 unselected line stays high", 32'(rise0), 32'd0);
    wr(A_CTRL, 32'h0A);
    chk("R10 clearing enable releases select", 32'(ssN), 32'h3);
    setCmd(8, 0, 0, 1, 0, 0, 0);
    wr(A_CTRL, 32'h4A);
    chk("R10 no keep, idle select high", 32'(ssN), 32'h3);
    rise1 = 0;
    prepSlave(0); wr(A_DATA, 32'hAA); waitTxEmpty(); wr(A_DATA, 32'h55); waitIdle();
    chk("R10 select released after each frame", 32'(rise1), 32'd2);
    setCmd(8, 0, 0, 2, 0, 0, 0);
    anyFall = 0;
    frame(32'h12, 0);
    chk("R10 code 2 selects no line", 32'(anyFall), 32'd0);
    setCmd(8, 0, 0, 0, 0, 0, 0);
    wr(A_CTRL, 32'h48);
  endtask

  task automatic tIrq();
    logic [31:0] v;
    wr(A_CTRL, 32'h68);
    chk("R11 irq from transmit-empty", 32'(irq), 32'h1);
    wr(A_CTRL, 32'hC8);
    chk("R11 irq low, receive-full clear", 32'(irq), 32'h0);
    frame(32'h5C, 32'h81);
    chk("R11 irq from receive-full", 32'(irq), 32'h1);
    rd(A_DATA, v);
    chk("R11 irq drops after read", 32'(irq), 32'h0);
    wr(A_CTRL, 32'h48);
  endtask

  task automatic finishAll();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tMode0Msb8();
    tLsb16Mode3();
    tRate();
    tOverrun();
    tTxOnly();
    tIgnoredWrite();
    tBusy();
    tSelect();
    tIrq();
    finishAll();
  end

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishAll();
  end
endmodule